// File: doc/BRIEF.md
# Supply Supervision Fault Controller

This block sits behind the debounced voltage comparators of a power-management die and turns their outputs into sticky status flags and protective control signals. It watches five conditions: main-supply undervoltage, high-side-supply undervoltage and overvoltage, a core-regulator prewarning and a core-regulator undervoltage. It also takes the current operating mode as an input.

From these inputs it drives three groups of outputs. One group is the status flags, which software clears through a write-one-to-clear port. The second group is two protective enables: one for the auxiliary regulator and one for the core short-circuit protection. The third group is an active-low reset with a restart-mode request. Each rail has its own fixed set of side effects. A configuration input keeps the auxiliary regulator on through a main-supply undervoltage. A flag can be cleared only once its fault has gone away.

Top module: `supv_fault_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all flags read 0 and `rst_n_o` is low.
- R2: A fault that is asserted in one cycle sets its flag bit in the next cycle and sets no other bit. Bit positions are: 0 main undervoltage, 1 high-side undervoltage, 2 high-side overvoltage, 3 core prewarning, 4 core undervoltage.
- R3: A flag that is set stays set after its fault is removed, until a clear is accepted.
- R4: A clear bit in `clr_i` clears its flag at the next edge only if that fault input is low in the clearing cycle. If the fault is high in the same cycle, the flag stays set.
- R5: `aux_en_o` is low in every cycle where `main_uv_i` is high and `aux_keep_on_i` is low. In all other cycles it is high. It returns high without any clear.
- R6: `scp_en_o` is low exactly in the cycles where `main_uv_i` is high, and it returns high automatically.
- R7: The high-side faults and the core prewarning change only their own flags. They have no effect on `aux_en_o`, `scp_en_o`, `rst_n_o` or `restart_req_o`.
- R8: Outside sleep mode, `core_uv_i` drives `rst_n_o` low in the same cycle and holds it low while the fault lasts. `rst_n_o` is released one cycle after the fault ends. `restart_req_o` is high exactly while `core_uv_i` is high.
- R9: In sleep mode (`mode_i` = 2'b10), the core prewarning and core undervoltage set no flag and assert neither reset nor restart request. The other mode encodings are 00 normal, 01 stop and 11 restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode: 00 normal, 01 stop, 10 sleep, 11 restart |
| main_uv_i | input | 1 | Main-supply undervoltage comparator |
| hs_uv_i | input | 1 | High-side-supply undervoltage comparator |
| hs_ov_i | input | 1 | High-side-supply overvoltage comparator |
| core_warn_i | input | 1 | Core-regulator prewarning comparator |
| core_uv_i | input | 1 | Core-regulator undervoltage comparator |
| aux_keep_on_i | input | 1 | Keep the auxiliary regulator on during main-supply undervoltage |
| clr_i | input | 5 | Write-one-to-clear requests, one per flag bit |
| flags_o | output | 5 | Sticky status flags |
| aux_en_o | output | 1 | Auxiliary regulator enable |
| scp_en_o | output | 1 | Core short-circuit protection enable |
| rst_n_o | output | 1 | Active-low reset output |
| restart_req_o | output | 1 | Request to enter restart mode |

## Verification
The assertions check these behaviours on every cycle:
- A flag is kept set while its fault is present, even when a clear is requested.
- An accepted clear empties the flag.
- A core flag cannot rise in sleep mode.
- A restart request always comes with reset asserted.
- Reset is still held in the cycle after the core fault falls.
- The auxiliary enable drops together with the short-circuit enable when there is no override.

Other behaviours can only be shown by the bench's scenarios. These are the exact one-cycle release of reset, the isolation of each fault to its own flag bit, and the automatic return of the enables. The bench compares every cycle of a long random run against a reference model to show them.

// File: rtl/supv_pkg.sv
package supv_pkg;

    localparam int FLAG_W = 5;

    localparam int IDX_MAIN_UV = 0;
    localparam int IDX_HS_UV   = 1;
    localparam int IDX_HS_OV   = 2;
    localparam int IDX_CORE_WN = 3;
    localparam int IDX_CORE_UV = 4;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_STOP    = 2'b01,
        MODE_SLEEP   = 2'b10,
        MODE_RESTART = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic core_uv;
        logic core_wn;
        logic hs_ov;
        logic hs_uv;
        logic main_uv;
    } fault_vec_t;

    // Faults whose flags are masked while the core regulator is off
    function automatic logic [FLAG_W-1:0] sleep_mask(input op_mode_e m);
        logic [FLAG_W-1:0] msk;
        msk = '1;
        if (m == MODE_SLEEP) begin
            msk[IDX_CORE_WN] = 1'b0;
            msk[IDX_CORE_UV] = 1'b0;
        end
        return msk;
    endfunction

endpackage

// File: rtl/supv_flag_bank.sv
module supv_flag_bank
    import supv_pkg::*;
#(
    parameter int N = FLAG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fault_raw,
    input  logic [N-1:0] set_en,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            logic flag_q;
            logic set_now;
            logic clr_ok;

            assign set_now = fault_raw[i] & set_en[i];
            assign clr_ok  = clr_req[i] & ~fault_raw[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                end else if (set_now) begin
                    flag_q <= 1'b1;
                end else if (clr_ok) begin
                    flag_q <= 1'b0;
                end
            end

            assign flags[i] = flag_q;

            AST_FLAG_HELD_UNDER_FAULT: assert property (@(posedge clk) disable iff (rst)
                (flag_q && fault_raw[i]) |=> flag_q); // R4
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
                (flag_q && !clr_req[i]) |=> flag_q); // R3
            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
                (clr_req[i] && !fault_raw[i]) |=> !flag_q); // R4
        end
    endgenerate

endmodule

// File: rtl/supv_action.sv
module supv_action
    import supv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  op_mode_e mode,
    input  logic     main_uv,
    input  logic     core_uv,
    input  logic     keep_on,
    output logic     aux_en,
    output logic     scp_en,
    output logic     rst_n,
    output logic     restart_req
);

    logic core_uv_eff;
    logic hold_q;

    assign core_uv_eff = core_uv & (mode != MODE_SLEEP);

    // Stretches reset by one cycle after the core fault ends; set during reset
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b1;
        end else begin
            hold_q <= core_uv_eff;
        end
    end

    always_comb begin
        aux_en      = ~main_uv | keep_on;
        scp_en      = ~main_uv;
        rst_n       = ~(core_uv_eff | hold_q);
        restart_req = core_uv_eff;
    end

    AST_RST_STRETCH: assert property (@(posedge clk) disable iff (rst)
        $fell(core_uv_eff) |-> !rst_n); // R8
    AST_RESTART_WITH_RST: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> !rst_n); // R8
    AST_AUX_FOLLOWS_SCP: assert property (@(posedge clk) disable iff (rst)
        (!scp_en && !keep_on) |-> !aux_en); // R5

endmodule

// File: rtl/supv_fault_ctrl.sv
module supv_fault_ctrl
    import supv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              main_uv_i,
    input  logic              hs_uv_i,
    input  logic              hs_ov_i,
    input  logic              core_warn_i,
    input  logic              core_uv_i,
    input  logic              aux_keep_on_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              aux_en_o,
    output logic              scp_en_o,
    output logic              rst_n_o,
    output logic              restart_req_o
);

    op_mode_e   mode;
    fault_vec_t faults;

    assign mode   = op_mode_e'(mode_i);
    assign faults = '{core_uv: core_uv_i, core_wn: core_warn_i, hs_ov: hs_ov_i,
                      hs_uv: hs_uv_i, main_uv: main_uv_i};

    supv_flag_bank #(.N(FLAG_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .fault_raw (faults),
        .set_en    (sleep_mask(mode)),
        .clr_req   (clr_i),
        .flags     (flags_o)
    );

    supv_action u_act (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .main_uv     (main_uv_i),
        .core_uv     (core_uv_i),
        .keep_on     (aux_keep_on_i),
        .aux_en      (aux_en_o),
        .scp_en      (scp_en_o),
        .rst_n       (rst_n_o),
        .restart_req (restart_req_o)
    );

    AST_SLEEP_NO_CORE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP && !flags_o[IDX_CORE_UV]) |=> !flags_o[IDX_CORE_UV]); // R9
    AST_SLEEP_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP) |-> !restart_req_o); // R9

endmodule

// File: tb/supv_fault_ctrl_test.sv
module supv_fault_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic main_uv_i = 0, hs_uv_i = 0, hs_ov_i = 0, core_warn_i = 0, core_uv_i = 0;
    logic aux_keep_on_i = 0;
    logic [W-1:0] clr_i = '0;
    logic [W-1:0] flags_o;
    logic aux_en_o, scp_en_o, rst_n_o, restart_req_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_flags = '0;
    logic exp_hold = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    supv_fault_ctrl uut (.*);

    function automatic logic [W-1:0] fault_vec();
        return {core_uv_i, core_warn_i, hs_ov_i, hs_uv_i, main_uv_i};
    endfunction

    function automatic logic [W-1:0] model_next(input logic [W-1:0] f, input logic [W-1:0] flt,
                                                 input logic [W-1:0] clr, input logic [1:0] md);
        logic [W-1:0] s;
        s = flt;
        if (md == 2'b10) s[4:3] = 2'b00;
        return s | (f & ~(clr & ~flt));
    endfunction

    function automatic logic core_eff();
        return core_uv_i && (mode_i != 2'b10);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Check all outputs against the model, then advance one clock
    task automatic step();
        #1;
        chk("R2 R3 R4 flags", flags_o, exp_flags);
        chk("R5 aux_en", aux_en_o, !main_uv_i || aux_keep_on_i);
        chk("R6 scp_en", scp_en_o, !main_uv_i);
        chk("R8 R9 rst_n", rst_n_o, !(core_eff() || exp_hold));
        chk("R8 R9 restart_req", restart_req_o, core_eff());
        @(posedge clk);
        exp_flags = model_next(exp_flags, fault_vec(), clr_i, mode_i);
        exp_hold  = core_eff();
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] md, input logic [W-1:0] flt,
                         input logic keep, input logic [W-1:0] clr);
        mode_i = md;
        {core_uv_i, core_warn_i, hs_ov_i, hs_uv_i, main_uv_i} = flt;
        aux_keep_on_i = keep;
        clr_i = clr;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R1 flags in reset", flags_o, 0);
        chk("R1 rst_n in reset", rst_n_o, 0);
        drive(2'b00, 5'b11111, 0, 0);
        @(negedge clk);
        chk("R1 flags ignore faults in reset", flags_o, 0);
        drive(2'b00, 0, 0, 0);
        rst = 1'b0;
        #1 chk("R1 rst_n first cycle after reset", rst_n_o, 0);
        @(negedge clk);
        exp_hold = 1'b0; exp_flags = '0;

        // R2: each fault alone sets only its own bit
        for (int i = 0; i < W; i++) begin
            drive(2'b00, 5'(1) << i, 0, 0);
            step();
            drive(2'b00, 0, 0, 5'h1f);
            #1 chk("R2 single fault bit", flags_o, 5'(1) << i);
            step();
            step();
        end
        // R7: high-side and warning faults leave protective outputs alone
        drive(2'b00, 5'b01110, 0, 0);
        #1 chk("R7 aux_en", aux_en_o, 1);
        chk("R7 scp_en", scp_en_o, 1);
        chk("R7 rst_n", rst_n_o, 1);
        chk("R7 restart_req", restart_req_o, 0);
        step();
        // R3: sticky after fault leaves
        drive(2'b00, 0, 0, 0);
        step(); step();
        #1 chk("R3 sticky flags", flags_o, 5'b01110);
        // R4: clear with fault present is refused
        drive(2'b00, 5'b00100, 0, 5'b00110);
        step();
        #1 chk("R4 clear blocked by live fault", flags_o, 5'b01100);
        drive(2'b00, 0, 0, 5'h1f);
        step();
        #1 chk("R4 clear accepted", flags_o, 0);
        // R5: keep-on override
        drive(2'b00, 5'b00001, 1, 0);
        #1 chk("R5 keep-on holds aux", aux_en_o, 1);
        chk("R6 scp off in main uv", scp_en_o, 0);
        step();
        drive(2'b00, 5'b00001, 0, 0);
        #1 chk("R5 aux off in main uv", aux_en_o, 0);
        step();
        drive(2'b00, 0, 0, 0);
        #1 chk("R5 aux auto restore", aux_en_o, 1);
        chk("R6 scp auto restore", scp_en_o, 1);
        step();
        // R8: reset stretch
        drive(2'b00, 5'b10000, 0, 0);
        #1 chk("R8 rst_n low same cycle", rst_n_o, 0);
        step(); step();
        drive(2'b00, 0, 0, 0);
        #1 chk("R8 rst_n held one cycle", rst_n_o, 0);
        chk("R8 restart drops", restart_req_o, 0);
        step();
        #1 chk("R8 rst_n released", rst_n_o, 1);
        drive(2'b00, 0, 0, 5'h1f);
        step();
        // R9: sleep masks core faults
        drive(2'b10, 5'b11000, 0, 0);
        #1 chk("R9 no reset in sleep", rst_n_o, 1);
        chk("R9 no restart in sleep", restart_req_o, 0);
        step();
        #1 chk("R9 no core flags in sleep", flags_o, 0);
        step();

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] f;
            f = 5'($urandom);
            f = f & 5'($urandom) & 5'($urandom);
            drive(2'($urandom), f, 1'($urandom), 5'($urandom) & 5'($urandom));
            step();
        end

        disable watchdog;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule